// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block keeps one 32-bit control and status word for each of up to 32 DMA channels. It also condenses the events of all channels into one summary word and a single interrupt line. The channel engines, which move the data, report short event pulses: a descriptor has started, a transfer has ended, or a bus error has occurred. They also report two live levels: a request is pending, and the engine has halted. In return each engine gets a run enable from this block.

Software reaches the block through a plain register bus: a write strobe, a byte address, write data, and read data that is returned combinationally from the address. Each channel word mixes three kinds of bits. Some are control bits that software can read and write. Some are read-only bits that show live state. The rest are sticky event flags that software clears by writing 1. A service routine reads the summary word and takes its lowest set bit. It reads that channel's word and writes the same value back. This clears every flag it saw and leaves the channel's control bits as they were.

Top module: `dma_chan_status_hub`

## Requirements
- R1: Channel N's word sits at byte offset N*4. Bit 31 is RUN, bit 30 is the no-fetch mode bit and bit 29 is the stop-interrupt enable. Each of these three bits reads back the value last written to it. All of them are 0 after reset.
- R2: Bit N of `run_o` follows channel N's RUN bit, one cycle after the write. After RUN is written 0, stop-state (bit 3) reads 1 from the next cycle onward.
- R3: Bit 8 of the word shows `req_pend_i[N]` live. Bit 3 shows stop-state live, which is the inverse of RUN ORed with `eng_halted_i[N]`. Writes to bits 8 and 3 have no effect, and neither do writes to the other undefined bits, which read 0.
- R4: Bits 2, 1 and 0 are sticky flags. Bit 2 records an end-of-transfer pulse, bit 1 a start-of-descriptor pulse and bit 0 a bus-error pulse. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R5: Writing back the exact value just read from a channel word clears every flag that was set. The control bits stay as they were, including RUN.
- R6: When a hardware event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R7: Bit N of the summary word at offset 0xF0 is 1 exactly when channel N has an enabled event pending. That is the case when any of the following holds: the end flag is set and `desc_end_ie_i[N]` is high; the start flag is set and `desc_start_ie_i[N]` is high; the bus-error flag is set; or stop-state and the stop-interrupt enable are both 1. Summary bits at or above the channel count read 0.
- R8: `irq_o` is high whenever any summary bit is 1. It stays high as a level until all enabled events have gone away.
- R9: Writes to the summary offset and to any unmapped offset change no state. Reads of unmapped offsets return 0.
- R10: After reset, `run_o` is 0, `irq_o` is 0, every flag is 0 and the summary word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_start_i | input | NUM_CH | Per-channel start-of-descriptor pulse |
| ev_end_i | input | NUM_CH | Per-channel end-of-transfer pulse |
| ev_err_i | input | NUM_CH | Per-channel bus-error pulse |
| eng_halted_i | input | NUM_CH | Per-channel level: the engine has stopped by itself |
| req_pend_i | input | NUM_CH | Per-channel level: a peripheral request is pending |
| desc_start_ie_i | input | NUM_CH | Start interrupt enable taken from the active descriptor |
| desc_end_ie_i | input | NUM_CH | End interrupt enable taken from the active descriptor |
| run_o | output | NUM_CH | Per-channel run enable to the engine |
| irq_o | output | 1 | Combined interrupt, level |

## Verification
The bench drives each flag with an event in the same cycle that software writes 1 to clear it. A design that lets the clear win would lose a completion. The bench also writes back words that were read with RUN set. A design that treats the write-back as a plain control write would get RUN right by accident, so the bench checks the flags cleared and the no-fetch and enable bits kept as a separate matter. End and start events are raised with their descriptor enables both low and high, and stop-state is raised with and without the stop enable. This catches a design that lets a gated event into the summary, or one that drops bus errors because they have no enable. Writes of all ones to the summary offset and to unmapped offsets show whether a design decodes too loosely and disturbs a channel word.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

   localparam int unsigned BIT_RUN     = 31;
   localparam int unsigned BIT_NOFETCH = 30;
   localparam int unsigned BIT_STOPIE  = 29;
   localparam int unsigned BIT_REQ     = 8;
   localparam int unsigned BIT_STOP    = 3;
   localparam int unsigned BIT_END     = 2;
   localparam int unsigned BIT_START   = 1;
   localparam int unsigned BIT_ERR     = 0;

   localparam int unsigned WORD_W      = 32;
   localparam logic [7:0]  SUMMARY_OFS = 8'hF0;

   typedef struct packed {
      logic run;
      logic nofetch;
      logic stop_ie;
   } ctrl_t;

   typedef struct packed {
      logic endf;
      logic startf;
      logic errf;
   } flags_t;

   function automatic logic [WORD_W-1:0] pack_word(ctrl_t c, logic req, logic stop, flags_t f);
      logic [WORD_W-1:0] w;
      w              = '0;
      w[BIT_RUN]     = c.run;
      w[BIT_NOFETCH] = c.nofetch;
      w[BIT_STOPIE]  = c.stop_ie;
      w[BIT_REQ]     = req;
      w[BIT_STOP]    = stop;
      w[BIT_END]     = f.endf;
      w[BIT_START]   = f.startf;
      w[BIT_ERR]     = f.errf;
      return w;
   endfunction

endpackage

// File: rtl/dsa_chan_word.sv
module dsa_chan_word
   import chstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              ev_start_i,
   input  logic              ev_end_i,
   input  logic              ev_err_i,
   input  logic              halted_i,
   input  logic              req_i,
   input  logic              start_ie_i,
   input  logic              end_ie_i,
   output logic [WORD_W-1:0] word_o,
   output logic              run_o,
   output logic              pend_o
);

   ctrl_t  ctrl_q;
   flags_t flg_q;
   flags_t flg_d;
   logic   stop_state;

   // Sticky flags: a write of 1 clears, and an event in the same cycle overrides the clear.
   always_comb begin
      flg_d.endf   = (flg_q.endf   & ~(wr_i & wdata_i[BIT_END]))   | ev_end_i;
      flg_d.startf = (flg_q.startf & ~(wr_i & wdata_i[BIT_START])) | ev_start_i;
      flg_d.errf   = (flg_q.errf   & ~(wr_i & wdata_i[BIT_ERR]))   | ev_err_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flg_q  <= '0;
      end else begin
         if (wr_i) begin
            ctrl_q.run     <= wdata_i[BIT_RUN];
            ctrl_q.nofetch <= wdata_i[BIT_NOFETCH];
            ctrl_q.stop_ie <= wdata_i[BIT_STOPIE];
         end
         flg_q <= flg_d;
      end
   end

   assign stop_state = ~ctrl_q.run | halted_i;
   assign run_o      = ctrl_q.run;
   assign word_o     = pack_word(ctrl_q, req_i, stop_state, flg_q);
   assign pend_o     = (flg_q.endf & end_ie_i) | (flg_q.startf & start_ie_i)
                     | flg_q.errf | (stop_state & ctrl_q.stop_ie);

   // R6
   end_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_end_i |=> word_o[BIT_END]);
   // R6
   start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start_i |=> word_o[BIT_START]);
   // R6
   err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err_i |=> word_o[BIT_ERR]);
   // R4
   end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_o[BIT_END] && !(wr_i && wdata_i[BIT_END])) |=> word_o[BIT_END]);
   // R4
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[BIT_ERR] && !ev_err_i) |=> !word_o[BIT_ERR]);
   // R2
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wdata_i[BIT_RUN]) |=> (!run_o && word_o[BIT_STOP]));

endmodule

// File: rtl/dsa_rd_mux.sv
module dsa_rd_mux
   import chstat_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [NUM_CH-1:0][WORD_W-1:0] words_i,
   input  logic [WORD_W-1:0]             summary_i,
   output logic [WORD_W-1:0]             rdata_o
);

   localparam int unsigned WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] widx;
   assign widx = addr_i[ADDR_W-1:2];

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(SUMMARY_OFS)) begin
         rdata_o = summary_i;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (widx == WIDX_W'(i)) rdata_o = words_i[i];
         end
      end
   end

endmodule

// File: rtl/dma_chan_status_hub.sv
module dma_chan_status_hub
   import chstat_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_CH-1:0] ev_start_i,
   input  logic [NUM_CH-1:0] ev_end_i,
   input  logic [NUM_CH-1:0] ev_err_i,
   input  logic [NUM_CH-1:0] eng_halted_i,
   input  logic [NUM_CH-1:0] req_pend_i,
   input  logic [NUM_CH-1:0] desc_start_ie_i,
   input  logic [NUM_CH-1:0] desc_end_ie_i,
   output logic [NUM_CH-1:0] run_o,
   output logic              irq_o
);

   localparam int unsigned WIDX_W = ADDR_W - 2;

   generate
      if (NUM_CH < 1 || NUM_CH > WORD_W) begin : g_bad_ch
         $error("NUM_CH must lie between 1 and 32");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must reach the summary offset");
      end
   endgenerate

   logic [NUM_CH-1:0]             wr_sel;
   logic [NUM_CH-1:0][WORD_W-1:0] words;
   logic [NUM_CH-1:0]             pend;
   logic [WORD_W-1:0]             summary;
   logic [WIDX_W-1:0]             widx;

   assign widx = bus_addr[ADDR_W-1:2];

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      assign wr_sel[gi] = bus_wr_en && (widx == WIDX_W'(gi));

      dsa_chan_word u_word (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_i       (wr_sel[gi]),
         .wdata_i    (bus_wdata),
         .ev_start_i (ev_start_i[gi]),
         .ev_end_i   (ev_end_i[gi]),
         .ev_err_i   (ev_err_i[gi]),
         .halted_i   (eng_halted_i[gi]),
         .req_i      (req_pend_i[gi]),
         .start_ie_i (desc_start_ie_i[gi]),
         .end_ie_i   (desc_end_ie_i[gi]),
         .word_o     (words[gi]),
         .run_o      (run_o[gi]),
         .pend_o     (pend[gi])
      );
   end

   assign summary = WORD_W'(pend);
   assign irq_o   = |pend;

   dsa_rd_mux #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_rd_mux (
      .addr_i    (bus_addr),
      .words_i   (words),
      .summary_i (summary),
      .rdata_o   (bus_rdata)
   );

   // R9
   sum_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == ADDR_W'(SUMMARY_OFS)) |=> $stable(run_o));
   // R9
   sum_onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

endmodule

// File: tb/dma_chan_status_hub_bench.sv
`timescale 1ns/1ps
module dma_chan_status_hub_bench;

   localparam int NCH = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr_en = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCH-1:0]  ev_start_i = '0, ev_end_i = '0, ev_err_i = '0;
   logic [NCH-1:0]  eng_halted_i = '0, req_pend_i = '0;
   logic [NCH-1:0]  desc_start_ie_i = '0, desc_end_ie_i = '0;
   logic [NCH-1:0]  run_o;
   logic            irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [NCH-1:0] m_run = '0, m_nf = '0, m_sie = '0;
   logic [NCH-1:0] m_end = '0, m_start = '0, m_err = '0;

   always #2.5 clk = ~clk;

   dma_chan_status_hub u_dma_chan_status_hub (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_start_i(ev_start_i),
      .ev_end_i(ev_end_i), .ev_err_i(ev_err_i), .eng_halted_i(eng_halted_i),
      .req_pend_i(req_pend_i), .desc_start_ie_i(desc_start_ie_i),
      .desc_end_ie_i(desc_end_ie_i), .run_o(run_o), .irq_o(irq_o));

   function automatic logic [31:0] exp_word(int i);
      logic [31:0] w;
      w = '0;
      w[31] = m_run[i]; w[30] = m_nf[i]; w[29] = m_sie[i];
      w[8]  = req_pend_i[i];
      w[3]  = ~m_run[i] | eng_halted_i[i];
      w[2]  = m_end[i]; w[1] = m_start[i]; w[0] = m_err[i];
      return w;
   endfunction

   function automatic logic [31:0] exp_sum();
      logic [31:0] s;
      s = '0;
      for (int i = 0; i < NCH; i++)
         s[i] = (m_end[i] & desc_end_ie_i[i]) | (m_start[i] & desc_start_ie_i[i]) | m_err[i]
              | ((~m_run[i] | eng_halted_i[i]) & m_sie[i]);
      return s;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model update at the clock edge, using the inputs held across it.
   task automatic step();
      logic [2:0] clr;
      @(posedge clk);
      for (int i = 0; i < NCH; i++) begin
         clr = '0;
         if (bus_wr_en && bus_addr[7:2] == 6'(i)) begin
            m_run[i] = bus_wdata[31]; m_nf[i] = bus_wdata[30]; m_sie[i] = bus_wdata[29];
            clr = bus_wdata[2:0];
         end
         m_end[i]   = (m_end[i]   & ~clr[2]) | ev_end_i[i];
         m_start[i] = (m_start[i] & ~clr[1]) | ev_start_i[i];
         m_err[i]   = (m_err[i]   & ~clr[0]) | ev_err_i[i];
      end
      #1;
      bus_wr_en = 1'b0; ev_start_i = '0; ev_end_i = '0; ev_err_i = '0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      step();
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic chk_word(int ch, string req);
      logic [31:0] d;
      rd(8'(ch * 4), d);
      chk(d == exp_word(ch), req, d, exp_word(ch));
   endtask

   task automatic chk_sum(string req);
      logic [31:0] d;
      rd(8'hF0, d);
      chk(d == exp_sum(), req, d, exp_sum());
      chk(irq_o == (exp_sum() != 0), "R8", 32'(irq_o), 32'(exp_sum() != 0));
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL WDOG actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, v, s;
      void'($urandom(32'h5EED_0DA7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      chk(run_o == '0, "R10", run_o, 0);
      chk_word(0, "R10");
      chk_sum("R10");

      // R1 control readback and R2 run output
      wr(8'h14, 32'hA000_0000);
      chk(run_o[5] == 1'b1, "R2", 32'(run_o[5]), 1);
      chk_word(5, "R1");
      wr(8'h14, 32'h2000_0000);
      chk(run_o[5] == 1'b0, "R2", 32'(run_o[5]), 0);
      rd(8'h14, d);
      chk(d[3] == 1'b1, "R2", d, exp_word(5));
      chk_sum("R7");                 // stop-state with stop enable pends
      wr(8'h14, 32'h0);
      chk_sum("R8");

      // R3 live bits ignore writes
      wr(8'h0C, 32'h8000_0108 | 32'h00F0_00F0);
      @(negedge clk); req_pend_i[3] = 1'b1;
      chk_word(3, "R3");
      @(negedge clk); eng_halted_i[3] = 1'b1;
      chk_word(3, "R3");
      @(negedge clk); req_pend_i[3] = 1'b0; eng_halted_i[3] = 1'b0;
      chk_word(3, "R3");

      // R4 sticky flag, write 0 keeps, write 1 clears
      @(negedge clk); ev_end_i[7] = 1'b1; step();
      chk_word(7, "R4");
      chk_sum("R7");                 // end enable low: no summary bit
      @(negedge clk); desc_end_ie_i[7] = 1'b1;
      chk_sum("R7");
      wr(8'h1C, 32'h0000_0003);
      chk_word(7, "R4");
      wr(8'h1C, 32'h0000_0004);
      chk_word(7, "R4");
      @(negedge clk); desc_end_ie_i[7] = 1'b0;

      // R6 event beats simultaneous clear
      @(negedge clk);
      bus_addr = 8'h28; bus_wdata = 32'h7; bus_wr_en = 1'b1;
      ev_err_i[10] = 1'b1; ev_start_i[10] = 1'b1;
      step();
      rd(8'h28, d);
      chk(d[1:0] == 2'b11, "R6", d, exp_word(10));
      wr(8'h28, 32'h7);
      chk_word(10, "R6");

      // R5 write-back of read value
      wr(8'h24, 32'hC000_0000);
      @(negedge clk); ev_end_i[9] = 1'b1; ev_start_i[9] = 1'b1; ev_err_i[9] = 1'b1; step();
      rd(8'h24, v);
      wr(8'h24, v);
      rd(8'h24, d);
      chk(d[2:0] == 3'b000 && d[31:30] == 2'b11, "R5", d, exp_word(9));

      // R7 lowest-bit service loop over two channels
      @(negedge clk); ev_err_i[2] = 1'b1; ev_err_i[20] = 1'b1; step();
      for (int k = 0; k < 2; k++) begin
         rd(8'hF0, s);
         for (int b = 0; b < NCH; b++) begin
            if (s[b]) begin
               rd(8'(b * 4), v);
               wr(8'(b * 4), v);
               break;
            end
         end
      end
      chk_sum("R7");
      chk_sum("R5");

      // R9 summary and unmapped writes
      v = run_o;
      wr(8'hF0, 32'hFFFF_FFFF);
      wr(8'h84, 32'hFFFF_FFFF);
      wr(8'hC0, 32'hFFFF_FFFF);
      chk(run_o == v, "R9", run_o, v);
      rd(8'h84, d);
      chk(d == 32'h0, "R9", d, 0);
      chk_sum("R9");

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         int ch;
         @(negedge clk);
         ev_end_i   = $urandom & $urandom & $urandom;
         ev_start_i = $urandom & $urandom & $urandom;
         ev_err_i   = $urandom & $urandom & $urandom & $urandom;
         req_pend_i = $urandom;
         eng_halted_i = $urandom & $urandom;
         if ($urandom_range(0, 15) == 0) desc_end_ie_i = $urandom;
         if ($urandom_range(0, 15) == 0) desc_start_ie_i = $urandom;
         ch = $urandom_range(0, NCH - 1);
         bus_addr = 8'(ch * 4);
         #0.4;
         chk(bus_rdata == exp_word(ch), "R4", bus_rdata, exp_word(ch));
         bus_addr = 8'hF0;
         #0.4;
         chk(bus_rdata == exp_sum(), "R7", bus_rdata, exp_sum());
         chk(irq_o == (exp_sum() != 0), "R8", 32'(irq_o), 32'(exp_sum() != 0));
         chk(run_o == m_run, "R2", run_o, m_run);
         case ($urandom_range(0, 7))
            0: begin bus_addr = 8'(ch * 4); bus_wdata = $urandom; bus_wr_en = 1'b1; end
            1: begin
               s = bus_rdata;
               for (int b = 0; b < NCH; b++) if (s[b]) begin ch = b; break; end
               bus_addr = 8'(ch * 4);
               #0.4;
               bus_wdata = bus_rdata; bus_wr_en = 1'b1;
            end
            2: begin bus_addr = 8'($urandom_range(128, 255)); bus_wdata = $urandom; bus_wr_en = 1'b1; end
            default: ;
         endcase
         step();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule